// File: doc/BRIEF.md
# RC4 Stream Cipher Engine

This block turns a byte stream into RC4 ciphertext, one byte per clock. A start pulse from idle opens a setup phase. The engine first raises a one-cycle request. The host then presents the key one byte per clock, and the engine keeps those bytes in a small internal buffer. Next the engine runs the 256-step key-scheduling pass over its 256-entry permutation. When the permutation is ready, the engine raises a one-cycle announcement. From the following cycle onward it takes one plaintext byte per clock. It returns that byte XORed with the next keystream byte, one cycle later.

A hold input freezes the keystream generator and the output register for as long as it is high. A stop pulse sends the engine back to idle from any phase. When the plaintext is all zeros, the output is the raw keystream, so the engine can also serve as a pseudo-random byte source.

Top module: `rc4_engine`

## Requirements
- R1: A `start` pulse sampled while idle makes `busy` high and `key_req` high in the next cycle. `key_req` stays high for exactly one cycle.
- R2: `key_len` is sampled with `start`, and the valid range is 1..KEY_MAX. The key bytes are taken from `key_byte` on the `key_len` consecutive cycles that follow the `key_req` cycle. Byte 0 comes first. When the key is shorter than 256 bytes, the key-scheduling pass reuses the key bytes cyclically.
- R3: `stream_go` is high for exactly one cycle, and that cycle comes `key_len`+257 cycles after the `key_req` cycle.
- R4: Each plaintext byte presented on a streaming cycle with `hold` low is XORed with the next RC4 keystream byte. The result appears on `cipher_byte` in the following cycle. The first plaintext byte is the one in the cycle after `stream_go`. For key "Key" and plaintext "Plaintext" the output is BB F3 16 E8 D9 40 AF 0A D3.
- R5: A plaintext of all 0x00 makes `cipher_byte` equal to the keystream bytes in order.
- R6: While `hold` is high, the keystream does not advance, the plaintext is ignored and `cipher_byte` keeps its value.
- R7: A `stop` pulse in any phase makes `busy` low in the next cycle. A later `start` begins a fresh setup whose output does not depend on the aborted session.
- R8: A `start` pulse while busy has no effect. It neither restarts the setup nor shifts the timing of `stream_go`.
- R9: After reset, `busy`, `key_req` and `stream_go` are low and `cipher_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_len | input | $clog2(KEY_MAX+1) | Key length in bytes, sampled with start |
| key_byte | input | 8 | Key byte stream during setup |
| plain_byte | input | 8 | Plaintext byte, one per streaming cycle |
| start | input | 1 | Begin setup (pulse, honoured only while idle) |
| stop | input | 1 | Abort and return to idle |
| hold | input | 1 | Freeze keystream and output while high |
| key_req | output | 1 | One-cycle request to begin sending key bytes |
| busy | output | 1 | High whenever the engine is not idle |
| stream_go | output | 1 | One-cycle pulse; plaintext starts the next cycle |
| cipher_byte | output | 8 | Encrypted byte, one cycle after its plaintext |

## Verification
The bench runs a behavioural RC4 model and compares `cipher_byte` with it on every streaming clock. It covers a 3-byte key, a 4-byte key, the full 16-byte key and zero-plaintext keystream runs.

- A design that drops the swap forwarding in the output lookup would go wrong on the rare byte whose output index equals i or j.
- A design with an off-by-one key index or request timing would produce a different ciphertext for the known vectors.
- A design that lets `hold` leak into the generator would skip or repeat a keystream byte during the periodic hold cycles.
- A design that restarts on a stray `start` would move `stream_go` away from its fixed delay.
- A design that keeps stale j or permutation state after a stop in mid-stream would fail the vector check on the session that follows.

// File: rtl/rc4_pkg.sv
package rc4_pkg;
    localparam int BYTE_W = 8;
    localparam int SBOX_N = 1 << BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REQ,
        PH_LOAD,
        PH_MIX,
        PH_ANN,
        PH_RUN
    } phase_e;

    typedef struct packed {
        logic fill;    // reset permutation to identity
        logic load;    // capture key byte
        logic mix;     // one key-scheduling swap
        logic rewind;  // clear i and j before streaming
        logic step;    // one keystream byte
    } ctl_t;

    // Value found at index t once the entries at ia (holding va) and
    // ja (holding vb) have traded places; vt is the pre-swap value at t.
    function automatic byte_t pick_after_swap(byte_t t, byte_t ia, byte_t ja,
                                              byte_t va, byte_t vb, byte_t vt);
        if (t == ia)      return vb;
        else if (t == ja) return va;
        else              return vt;
    endfunction
endpackage

// File: rtl/rc4_ctrl.sv
module rc4_ctrl
    import rc4_pkg::*;
#(
    parameter int KEY_MAX = 16,
    parameter int KL_W    = $clog2(KEY_MAX + 1),
    parameter int KI_W    = $clog2(KEY_MAX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            stop,
    input  logic            hold,
    input  logic [KL_W-1:0] key_len,
    output ctl_t            ctl,
    output logic [KL_W-1:0] len_q,
    output logic [KI_W-1:0] key_pos,
    output logic            key_req,
    output logic            stream_go,
    output logic            busy
);
    phase_e          ph;
    byte_t           cnt;
    logic [KL_W-1:0] len_fit;

    always_comb begin
        if (key_len == '0)                  len_fit = KL_W'(1);
        else if (key_len > KL_W'(KEY_MAX))  len_fit = KL_W'(KEY_MAX);
        else                                len_fit = key_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            len_q <= KL_W'(1);
        end else if (stop) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    ph    <= PH_REQ;
                    len_q <= len_fit;
                    cnt   <= '0;
                end
                PH_REQ:  ph <= PH_LOAD;
                PH_LOAD: begin
                    if (cnt == BYTE_W'(len_q) - BYTE_W'(1)) begin
                        ph  <= PH_MIX;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + BYTE_W'(1);
                    end
                end
                PH_MIX: begin
                    cnt <= cnt + BYTE_W'(1);
                    if (cnt == '1) ph <= PH_ANN;
                end
                PH_ANN:  ph <= PH_RUN;
                PH_RUN:  ph <= PH_RUN;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign key_pos    = cnt[KI_W-1:0];
    assign key_req    = (ph == PH_REQ);
    assign stream_go  = (ph == PH_ANN);
    assign busy       = (ph != PH_IDLE);
    assign ctl.fill   = (ph == PH_REQ);
    assign ctl.load   = (ph == PH_LOAD);
    assign ctl.mix    = (ph == PH_MIX);
    assign ctl.rewind = (ph == PH_ANN);
    assign ctl.step   = (ph == PH_RUN) && !hold;

    assert_key_req_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        key_req |=> !key_req);
    assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    assert_go_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        stream_go |=> !stream_go);
    assert_stop_idles_R7: assert property (@(posedge clk) disable iff (rst)
        stop |=> !busy);
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !stop && !key_req) |=> !key_req);
endmodule

// File: rtl/rc4_keybuf.sv
module rc4_keybuf
    import rc4_pkg::*;
#(
    parameter int KEY_MAX = 16,
    parameter int KL_W    = $clog2(KEY_MAX + 1),
    parameter int KI_W    = $clog2(KEY_MAX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fill,
    input  logic            load,
    input  logic            mix,
    input  logic [KL_W-1:0] len_q,
    input  logic [KI_W-1:0] wr_pos,
    input  byte_t           key_byte,
    output byte_t           kb
);
    byte_t           mem [KEY_MAX];
    logic [KI_W-1:0] rd;

    always_ff @(posedge clk) begin
        if (load) mem[wr_pos] <= key_byte;
    end

    always_ff @(posedge clk) begin
        if (rst || fill)
            rd <= '0;
        else if (mix)
            rd <= (KL_W'(rd) == len_q - KL_W'(1)) ? '0 : rd + KI_W'(1);
    end

    assign kb = mem[rd];

    assert_key_index_R2: assert property (@(posedge clk) disable iff (rst)
        mix |-> (KL_W'(rd) < len_q));
endmodule

// File: rtl/rc4_sbox.sv
module rc4_sbox
    import rc4_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    input  byte_t kb,
    input  byte_t plain,
    output byte_t cipher
);
    byte_t s [SBOX_N];
    byte_t ii, jj;
    byte_t m_si, m_j, m_sj;
    byte_t r_i, r_si, r_j, r_sj, r_t, r_k;

    always_comb begin
        m_si = s[ii];
        m_j  = jj + m_si + kb;
        m_sj = s[m_j];
        r_i  = ii + BYTE_W'(1);
        r_si = s[r_i];
        r_j  = jj + r_si;
        r_sj = s[r_j];
        r_t  = r_si + r_sj;
        r_k  = pick_after_swap(r_t, r_i, r_j, r_si, r_sj, s[r_t]);
    end

    always_ff @(posedge clk) begin
        if (ctl.fill) begin
            for (int n = 0; n < SBOX_N; n++) s[n] <= BYTE_W'(n);
        end else if (ctl.mix) begin
            s[ii]  <= m_sj;
            s[m_j] <= m_si;
        end else if (ctl.step) begin
            s[r_i] <= r_sj;
            s[r_j] <= r_si;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.fill || ctl.rewind) begin
            ii <= '0;
            jj <= '0;
        end else if (ctl.mix) begin
            ii <= ii + BYTE_W'(1);
            jj <= m_j;
        end else if (ctl.step) begin
            ii <= r_i;
            jj <= r_j;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           cipher <= '0;
        else if (ctl.step) cipher <= plain ^ r_k;
    end

    assert_hold_freezes_R6: assert property (@(posedge clk) disable iff (rst)
        !ctl.step |=> $stable(cipher));
endmodule

// File: rtl/rc4_engine.sv
module rc4_engine
    import rc4_pkg::*;
#(
    parameter int KEY_MAX = 16,
    localparam int KL_W   = $clog2(KEY_MAX + 1),
    localparam int KI_W   = $clog2(KEY_MAX)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [KL_W-1:0] key_len,
    input  logic [7:0]      key_byte,
    input  logic [7:0]      plain_byte,
    input  logic            start,
    input  logic            stop,
    input  logic            hold,
    output logic            key_req,
    output logic            busy,
    output logic            stream_go,
    output logic [7:0]      cipher_byte
);
    ctl_t            ctl;
    logic [KL_W-1:0] len_q;
    logic [KI_W-1:0] key_pos;
    byte_t           kb;

    rc4_ctrl #(.KEY_MAX(KEY_MAX), .KL_W(KL_W), .KI_W(KI_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .hold(hold),
        .key_len(key_len), .ctl(ctl), .len_q(len_q), .key_pos(key_pos),
        .key_req(key_req), .stream_go(stream_go), .busy(busy)
    );

    rc4_keybuf #(.KEY_MAX(KEY_MAX), .KL_W(KL_W), .KI_W(KI_W)) u_keys (
        .clk(clk), .rst(rst), .fill(ctl.fill), .load(ctl.load), .mix(ctl.mix),
        .len_q(len_q), .wr_pos(key_pos), .key_byte(key_byte), .kb(kb)
    );

    rc4_sbox u_sbox (
        .clk(clk), .rst(rst), .ctl(ctl), .kb(kb),
        .plain(plain_byte), .cipher(cipher_byte)
    );
endmodule

// File: tb/rc4_engine_test.sv
module rc4_engine_test;
    typedef int iq_t[$];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] key_len = 5'd1;
    logic [7:0] key_byte = '0, plain_byte = '0;
    logic       start = 1'b0, stop = 1'b0, hold = 1'b0;
    logic       key_req, busy, stream_go;
    logic [7:0] cipher_byte;

    int n_run = 0, n_bad = 0;
    bit done = 0;
    int ks[$];

    always #10 clk = ~clk;

    rc4_engine #(.KEY_MAX(16)) uut (
        .clk(clk), .rst(rst), .key_len(key_len), .key_byte(key_byte),
        .plain_byte(plain_byte), .start(start), .stop(stop), .hold(hold),
        .key_req(key_req), .busy(busy), .stream_go(stream_go),
        .cipher_byte(cipher_byte)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic iq_t str2q(string s);
        iq_t q;
        for (int c = 0; c < s.len(); c++) q.push_back(int'(s[c]));
        return q;
    endfunction

    // behavioural keystream model
    task automatic make_ks(input iq_t k, input int n);
        int s[256];
        int i = 0, j = 0, t;
        ks.delete();
        for (int a = 0; a < 256; a++) s[a] = a;
        for (int a = 0; a < 256; a++) begin
            j = (j + s[a] + k[a % k.size()]) % 256;
            t = s[a]; s[a] = s[j]; s[j] = t;
        end
        j = 0;
        for (int b = 0; b < n; b++) begin
            i = (i + 1) % 256;
            j = (j + s[i]) % 256;
            t = s[i]; s[i] = s[j]; s[j] = t;
            ks.push_back(s[(s[i] + s[j]) % 256]);
        end
    endtask

    task automatic setup(input iq_t k, input bit poke_start);
        int waited = 0;
        @(negedge clk);
        key_len = 5'(k.size());
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(key_req == 1'b1, "R1 key_req", int'(key_req), 1);
        check(busy == 1'b1, "R1 busy", int'(busy), 1);
        foreach (k[x]) begin
            @(negedge clk);
            if (x == 0) check(key_req == 1'b0, "R1 pulse width", int'(key_req), 0);
            key_byte = 8'(k[x]);
        end
        while (!stream_go && waited < 400) begin
            @(negedge clk);
            waited++;
            if (poke_start && waited == 20) start = 1'b1;
            if (poke_start && waited == 21) start = 1'b0;
        end
        check(waited == k.size() + 257 - k.size() + k.size() - k.size(),
              "R3 go delay after last key byte", waited, 257);
    endtask

    task automatic stream(input iq_t pt, input int hold_every, output iq_t got);
        int  n = 0, idx = 0, prev_plain = 0, exp_c;
        bit  prev_active = 0;
        bit  h;
        got.delete();
        exp_c = int'(cipher_byte);
        for (int c = 0; idx < pt.size() || prev_active; c++) begin
            @(negedge clk);
            if (c == 0) check(stream_go == 1'b0, "R3 go width", int'(stream_go), 0);
            if (prev_active) begin
                exp_c = (prev_plain ^ ks[n]) & 8'hFF;
                n++;
                got.push_back(int'(cipher_byte));
                check(int'(cipher_byte) == exp_c, "R4 cipher vs model", int'(cipher_byte), exp_c);
            end else begin
                check(int'(cipher_byte) == exp_c, "R6 held output", int'(cipher_byte), exp_c);
            end
            if (idx < pt.size()) begin
                h = (hold_every > 0) && (c % hold_every == hold_every - 1);
                hold = h;
                plain_byte = 8'(pt[idx]);
                if (h) begin
                    plain_byte = 8'hA5;
                    prev_active = 0;
                end else begin
                    prev_plain = pt[idx];
                    idx++;
                    prev_active = 1;
                end
            end else begin
                hold = 1'b0;
                plain_byte = '0;
                prev_active = 0;
            end
        end
    endtask

    task automatic cmp_vec(input iq_t got, input iq_t exp, input string tag);
        check(got.size() == exp.size(), tag, got.size(), exp.size());
        foreach (exp[x]) if (x < got.size()) check(got[x] == exp[x], tag, got[x], exp[x]);
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check(busy == 1'b0, "R7 busy after stop", int'(busy), 0);
        check(key_req == 1'b0 && stream_go == 1'b0, "R7 idle pulses", int'({key_req, stream_go}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        iq_t key, pt, got, zeros;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(busy == 1'b0, "R9 busy", int'(busy), 0);
        check(key_req == 1'b0, "R9 key_req", int'(key_req), 0);
        check(stream_go == 1'b0, "R9 stream_go", int'(stream_go), 0);
        check(cipher_byte == 8'h00, "R9 cipher", int'(cipher_byte), 0);

        // R4 known vector, no hold
        key = str2q("Key");
        pt  = str2q("Plaintext");
        make_ks(key, pt.size());
        setup(key, 1'b0);
        stream(pt, 0, got);
        cmp_vec(got, '{'hBB, 'hF3, 'h16, 'hE8, 'hD9, 'h40, 'hAF, 'h0A, 'hD3}, "R4 known vector");

        // R6 periodic hold, R8 stray start during setup
        pulse_stop();
        key = str2q("Wiki");
        pt  = str2q("pedia");
        make_ks(key, pt.size());
        setup(key, 1'b1);
        stream(pt, 3, got);
        cmp_vec(got, '{'h10, 'h21, 'hBF, 'h04, 'h20}, "R6 R8 vector with hold");

        // R5 keystream mode with full-length key (R2 cyclic reuse)
        pulse_stop();
        key.delete();
        for (int b = 0; b < 16; b++) key.push_back((b * 37 + 11) & 255);
        zeros.delete();
        for (int b = 0; b < 40; b++) zeros.push_back(0);
        make_ks(key, zeros.size());
        setup(key, 1'b0);
        stream(zeros, 0, got);
        cmp_vec(got, ks, "R5 R2 keystream");

        // R7 stop during key scheduling
        pulse_stop();
        @(negedge clk);
        key_len = 5'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        check(busy == 1'b1, "R7 busy mid setup", int'(busy), 1);
        pulse_stop();
        repeat (5) @(negedge clk);
        check(busy == 1'b0, "R7 stays idle", int'(busy), 0);

        // R7 stop mid-stream, then fresh session
        key = str2q("Key");
        pt  = str2q("Plain");
        make_ks(key, pt.size());
        setup(key, 1'b0);
        stream(pt, 2, got);
        pulse_stop();
        pt = str2q("Plaintext");
        make_ks(key, pt.size());
        setup(key, 1'b0);
        stream(pt, 0, got);
        cmp_vec(got, '{'hBB, 'hF3, 'h16, 'hE8, 'hD9, 'h40, 'hAF, 'h0A, 'hD3}, "R7 fresh session");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule